// File: doc/BRIEF.md
# Write-Cycle Status Read Responder

This block sits in the read data path of a self-timed nonvolatile byte memory. It shows the host whether an internal programming cycle is still running. While the write controller reports a cycle in progress, the byte placed on the data bus is replaced by status. Its top bit carries the inverse of the top bit of the last byte loaded, but only when the host reads back that same address. The bit below it changes value on every read. The low bits are zero. Once the controller goes idle, the array contents pass through unchanged.

The host can use either method to detect completion. The first compares the top bit against the data it wrote and waits until they match. The second reads twice and waits until the toggling bit stops changing. A write that the protection logic rejects disarms the polling bit, so no false status is shown for a byte that was never stored. Read strobes are decoded from active-low chip enable and output enable. Each cycle, inputs are sampled on the rising clock edge.

Top module: `wr_status_resp`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both 0; while `dq_oe` is 0, `dq_out` is all zeros. After reset, with both strobes high, `dq_oe` is 0.
- R2: While `prog_busy` is 0 and a read is enabled, `dq_out` equals `arr_data` in the same cycle.
- R3: While `prog_busy` is 1, polling is armed and `rd_addr` equals the last committed address, bit 7 of `dq_out` is the inverse of bit 7 of the last committed data byte.
- R4: While `prog_busy` is 1, bit 6 of `dq_out` reverses once for each read strobe. A read strobe is a clock edge at which `oe_n` is sampled low after being high one edge earlier, with `ce_n` low at that edge. A fall of `oe_n` while `ce_n` is high does not change bit 6, and neither does a strobe while `prog_busy` is 0. The starting value of bit 6 is unspecified.
- R5: While `prog_busy` is 1, bits 5 to 0 of `dq_out` are zero. Bit 7 is zero when the address differs from the last committed one, or when polling is not armed.
- R6: Reset leaves polling disarmed. A `wr_reject` pulse disarms polling, and the next `wr_commit` arms it again. When both pulse in the same cycle, the commit wins.
- R7: In the cycle `prog_busy` falls, `dq_out` switches to `arr_data`, including the true bit 7. A strobe in that cycle leaves the toggle state unchanged.
- R8: Each `wr_commit` captures `wr_addr` and `wr_data`. After several commits (a page load), only the most recent address shows inverted polling status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_busy | input | 1 | Internal programming cycle in progress |
| wr_commit | input | 1 | One-cycle pulse: a byte load was accepted |
| wr_reject | input | 1 | One-cycle pulse: a write was refused by protection |
| wr_addr | input | ADDR_W (17) | Address of the byte being loaded |
| wr_data | input | DATA_W (8) | Data of the byte being loaded |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W (17) | Read address |
| arr_data | input | DATA_W (8) | Data read from the array |
| dq_out | output | DATA_W (8) | Byte driven onto the data bus |
| dq_oe | output | 1 | Data bus drive enable (low means high impedance) |

## Verification
Completion of a programming cycle and a read strobe can land in the same clock cycle. The toggle register and the output source select then both react to one edge. The bench lowers `oe_n` in the same cycle it drops `prog_busy`. It checks that the bus already carries array data in that cycle. It then goes busy again and confirms, from one further read, that exactly one reversal has occurred since the last busy read. The same reasoning is used to show that strobes with chip enable high, and strobes while idle, leave the toggle state alone.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  parameter int unsigned ADDR_W_DEF = 17;
  parameter int unsigned DATA_W_DEF = 8;
  parameter int unsigned SYNC_DEF   = 2;

  // Source of the byte placed on the bus
  typedef enum logic [1:0] {
    SRC_FLOAT  = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } dq_src_e;

  // Tracked write-cycle status
  typedef struct packed {
    logic armed;
    logic tog;
  } wcs_flags_t;

endpackage

// File: rtl/wcs_rst_sync.sv
module wcs_rst_sync #(
  parameter int unsigned STAGES = wcs_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/wcs_strobe_det.sv
module wcs_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic rd_en,
  output logic rd_fall
);

  logic oe_q;
  logic oe_d;

  always_comb begin
    oe_d = oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b1;
    else        oe_q <= oe_d;
  end

  assign rd_en   = !ce_n && !oe_n;
  assign rd_fall = oe_q && !oe_n && !ce_n;

  // a strobe can only be seen with the read enabled
  AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |-> rd_en); // R4

  // two strobes need oe_n to rise in between
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> !rd_fall); // R4

endmodule

// File: rtl/wcs_status_track.sv
module wcs_status_track
  import wcs_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_busy,
  input  logic              wr_commit,
  input  logic              wr_reject,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_fall,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data,
  output wcs_flags_t        flags
);

  logic              cap_en;
  logic              arm_en;
  logic              tog_en;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  wcs_flags_t        flg_q, flg_d;

  // next state
  always_comb begin
    cap_en = wr_commit;
    arm_en = wr_commit || wr_reject;
    tog_en = rd_fall && prog_busy;
    addr_d = addr_q;
    data_d = data_q;
    flg_d  = flg_q;
    if (cap_en) begin
      addr_d = wr_addr;
      data_d = wr_data;
    end
    if (arm_en) flg_d.armed = wr_commit;
    if (tog_en) flg_d.tog   = !flg_q.tog;
  end

  // registers, each with an explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q.armed <= 1'b0;
    else if (arm_en) flg_q.armed <= flg_d.armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q.tog <= 1'b0;
    else if (tog_en) flg_q.tog <= flg_d.tog;
  end

  assign last_addr = addr_q;
  assign last_data = data_q;
  assign flags     = flg_q;

  AST_CAPTURE_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (last_addr == $past(wr_addr)) && (last_data == $past(wr_data))); // R8

  AST_REJECT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reject && !wr_commit) |=> !flags.armed); // R6

  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> flags.armed); // R6

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fall && prog_busy) |=> $stable(flags.tog)); // R4

endmodule

// File: rtl/wcs_dq_mux.sv
module wcs_dq_mux
  import wcs_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              prog_busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  wcs_flags_t        flags,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  dq_src_e           src;
  logic              hit;
  logic [DATA_W-1:0] status;
  logic              unused_low;

  assign unused_low = ^last_data[DATA_W-2:0];
  assign hit        = flags.armed && (rd_addr == last_addr);

  always_comb begin
    if (!rd_en)         src = SRC_FLOAT;
    else if (prog_busy) src = SRC_STATUS;
    else                src = SRC_ARRAY;
  end

  // status byte: polling bit, toggle bit, reserved zeros
  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_stat
      if (b == POLL_BIT) begin : g_poll
        assign status[b] = hit && !last_data[POLL_BIT];
      end else if (b == TOG_BIT) begin : g_tog
        assign status[b] = flags.tog;
      end else begin : g_rsvd
        assign status[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    case (src)
      SRC_STATUS: dq_out = status;
      SRC_ARRAY:  dq_out = arr_data;
      default:    dq_out = '0;
    endcase
  end

  assign dq_oe = (src != SRC_FLOAT);

endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp
  import wcs_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_busy,
  input  logic              wr_commit,
  input  logic              wr_reject,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  logic              rst_sync_n;
  logic              rd_en;
  logic              rd_fall;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  wcs_flags_t        flags;

  wcs_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wcs_strobe_det u_strobe (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .rd_en   (rd_en),
    .rd_fall (rd_fall)
  );

  wcs_status_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .prog_busy (prog_busy),
    .wr_commit (wr_commit),
    .wr_reject (wr_reject),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_fall   (rd_fall),
    .last_addr (last_addr),
    .last_data (last_data),
    .flags     (flags)
  );

  wcs_dq_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .prog_busy (prog_busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .last_addr (last_addr),
    .last_data (last_data),
    .flags     (flags),
    .arr_data  (arr_data),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dq_oe |-> (dq_out == '0)); // R1

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!prog_busy && dq_oe) |-> (dq_out == arr_data)); // R2

  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_busy && dq_oe && flags.armed && rd_addr == last_addr)
      |-> (dq_out[POLL_BIT] != last_data[POLL_BIT])); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prog_busy |-> (dq_out[TOG_BIT-1:0] == '0)); // R5

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_busy && rd_fall) |=> (!prog_busy || !dq_oe ||
                                dq_out[TOG_BIT] != $past(dq_out[TOG_BIT]))); // R4

endmodule

// File: tb/test_wr_status_resp.sv
module test_wr_status_resp;

  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_busy;
  logic          wr_commit;
  logic          wr_reject;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          ce_n;
  logic          oe_n;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  wr_status_resp i_wr_status_resp (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy),
    .wr_commit(wr_commit), .wr_reject(wr_reject),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .ce_n(ce_n), .oe_n(oe_n), .rd_addr(rd_addr),
    .arr_data(arr_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic commit(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_commit = 1'b1;
    @(negedge clk);
    wr_commit = 1'b0;
  endtask

  // one read strobe; returns bus value sampled one edge after the strobe
  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic o);
    @(negedge clk);
    rd_addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = dq_out; o = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk("R1 reset oe", dq_oe, 0);
    chk("R1 reset data", dq_out, 0);
    ce_n = 1'b0; #1;
    chk("R1 ce only oe", dq_oe, 0);
    chk("R1 ce only data", dq_out, 0);
    ce_n = 1'b1;
  endtask

  task automatic t_idle();
    logic [DW-1:0] d; logic o;
    arr_data = 8'hA5;
    rd(17'h00123, d, o);
    chk("R1 read enables", o, 1);
    chk("R2 idle pass A5", d, 8'hA5);
    arr_data = 8'h3C;
    rd(17'h1F000, d, o);
    chk("R2 idle pass 3C", d, 8'h3C);
  endtask

  task automatic t_unarmed();
    logic [DW-1:0] d; logic o;
    prog_busy = 1'b1; arr_data = 8'hFF;
    rd(17'h0, d, o);
    chk("R6 unarmed after reset bit7", d[7], 0);
    chk("R5 reserved zero", d[5:0], 0);
    prog_busy = 1'b0;
  endtask

  task automatic t_poll();
    logic [DW-1:0] d; logic o;
    commit(17'h15555, 8'h4B);
    prog_busy = 1'b1; arr_data = 8'h77;
    rd(17'h15555, d, o);
    chk("R3 poll inverted of 0", d[7], 1);
    chk("R5 reserved zero busy", d[5:0], 0);
    prog_busy = 1'b0;
    commit(17'h02AAA, 8'hC3);
    prog_busy = 1'b1;
    rd(17'h02AAA, d, o);
    chk("R3 poll inverted of 1", d[7], 0);
    prog_busy = 1'b0;
  endtask

  task automatic t_page();
    logic [DW-1:0] d; logic o;
    commit(17'h00100, 8'h80);
    commit(17'h00101, 8'h7F);
    prog_busy = 1'b1;
    rd(17'h00101, d, o);
    chk("R8 latest address polls", d[7], 1);
    rd(17'h00100, d, o);
    chk("R5 R8 earlier page byte bit7", d[7], 0);
    prog_busy = 1'b0;
  endtask

  task automatic t_toggle();
    logic [DW-1:0] a, b, c; logic o;
    prog_busy = 1'b1;
    rd(17'h00055, a, o);
    rd(17'h00055, b, o);
    rd(17'h00999, c, o);
    chk("R4 toggle second read", b[6], !a[6]);
    chk("R4 toggle third read", c[6], !b[6]);
    prog_busy = 1'b0;
  endtask

  task automatic t_ce_high();
    logic [DW-1:0] a, b; logic o;
    prog_busy = 1'b1;
    rd(17'h00010, a, o);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); #1;
    chk("R1 ce high no drive", dq_oe, 0);
    oe_n = 1'b1;
    @(negedge clk);
    rd(17'h00010, b, o);
    chk("R4 ce high strobe ignored", b[6], !a[6]);
    prog_busy = 1'b0;
  endtask

  task automatic t_idle_hold();
    logic [DW-1:0] a, b, m; logic o;
    prog_busy = 1'b1;
    rd(17'h00020, a, o);
    prog_busy = 1'b0; arr_data = 8'h5A;
    rd(17'h00020, m, o);
    chk("R2 idle between busy", m, 8'h5A);
    prog_busy = 1'b1;
    rd(17'h00020, b, o);
    chk("R4 idle strobe leaves toggle", b[6], !a[6]);
    prog_busy = 1'b0;
  endtask

  task automatic t_reject();
    logic [DW-1:0] d; logic o;
    commit(17'h00444, 8'h10);
    @(negedge clk); wr_reject = 1'b1;
    @(negedge clk); wr_reject = 1'b0;
    prog_busy = 1'b1;
    rd(17'h00444, d, o);
    chk("R6 reject disarms poll", d[7], 0);
    prog_busy = 1'b0;
    @(negedge clk);
    wr_addr = 17'h00445; wr_data = 8'h01; wr_commit = 1'b1; wr_reject = 1'b1;
    @(negedge clk); wr_commit = 1'b0; wr_reject = 1'b0;
    prog_busy = 1'b1;
    rd(17'h00445, d, o);
    chk("R6 commit wins over reject", d[7], 1);
    prog_busy = 1'b0;
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] a, b; logic o;
    commit(17'h00777, 8'h22);
    arr_data = 8'h22;
    prog_busy = 1'b1;
    rd(17'h00777, a, o);
    chk("R3 before completion", a[7], 1);
    @(negedge clk);
    rd_addr = 17'h00777; ce_n = 1'b0; oe_n = 1'b0; prog_busy = 1'b0;
    #1;
    chk("R7 true data in completion cycle", dq_out, 8'h22);
    @(negedge clk);
    chk("R7 true data after completion", dq_out, 8'h22);
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    prog_busy = 1'b1;
    rd(17'h00777, b, o);
    chk("R7 completion strobe leaves toggle", b[6], !a[6]);
    prog_busy = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; prog_busy = 1'b0; wr_commit = 1'b0; wr_reject = 1'b0;
    wr_addr = '0; wr_data = '0; ce_n = 1'b1; oe_n = 1'b1;
    rd_addr = '0; arr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle();
    t_unarmed();
    t_poll();
    t_page();
    t_toggle();
    t_ce_high();
    t_idle_hold();
    t_reject();
    t_same_cycle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule